// File: doc/BRIEF.md
# Single-Event Countdown Timer Channel

The block is one channel of a 16-bit down-counting interval timer, restricted to the three modes that produce a single event per arming: an interrupt-style flag at terminal count, a gate-triggered retriggerable one-shot pulse, and a gate-triggered one-period strobe. It runs entirely on the system clock. The slow count input is presented as a one-cycle `tick` strobe, and each strobe stands for one falling edge of that input. A separate register front end (not part of this block) decodes bus accesses into three pulses: a mode write carrying a mode code and a BCD select, a "first byte written" pulse that freezes the channel while a two-byte reload value is being assembled, and a "reload complete" pulse carrying the full 16-bit value.

The output pin level is set by mode writes, by reload completion, by gate rising edges and by the count stepping from one to zero. After terminal count the counter keeps wrapping and decrementing, in binary or in BCD, without changing the output again. The live count is exposed unregistered on `count_q` for an external latch stage.

Top module: `oneshot_timer_chan`

## Requirements
- R1: After reset `out_pin` is 1 and `count_q` is 0, and ticks leave the count unchanged until a mode write and a reload have been received.
- R2: A mode write with `mode_code` 2'b00 (terminal-count flag mode) drives `out_pin` to 0 on the next clock. After `reload_done`, the first tick loads `reload_val` into the count. Later ticks decrement only while the gate sampled one system clock earlier is 1.
- R3: In mode 2'b00 and mode 2'b01 (one-shot), the tick that steps the count from 1 to 0 sets `out_pin` to 1. It stays 1 through later ticks until the next mode write or `reload_done`, and in mode 2'b00 a `reload_done` drives it back to 0.
- R4: A tick at count 0 wraps the count to 16'hFFFF when binary, or to 16'h9999 when `bcd_sel` was 1 at the mode write, and decrementing continues without changing `out_pin`. BCD counting decrements each 4-bit field as a decimal digit.
- R5: A `first_byte` pulse halts the channel: ticks neither decrement nor load until `reload_done`, after which the next tick loads the new value.
- R6: A mode write with `mode_code` 2'b01 drives `out_pin` to 1. After `reload_done` the channel waits, with the count frozen, for a gate rising edge. The edge drives `out_pin` to 0 on the second clock edge after `gate` rises, and the next tick loads the count.
- R7: In modes 2'b01 and 2'b10, the gate going low has no effect on counting. A new gate rising edge makes the next tick reload the count and restart the sequence.
- R8: A mode write with `mode_code` 2'b10 (strobe; 2'b11 acts the same) drives `out_pin` to 1. After `reload_done` and a gate rising edge, the next tick loads the count. The tick that steps 1 to 0 drives `out_pin` to 0 until the following tick, which restores 1.
- R9: A reload value of 0 is loaded as 0 and reaches terminal count after 65536 decrementing ticks in binary, or 10000 in BCD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe per count-input falling edge |
| gate | input | 1 | Gate level, asynchronous to the tick |
| mode_wr | input | 1 | Mode write pulse |
| mode_code | input | 2 | Mode select carried with `mode_wr` |
| bcd_sel | input | 1 | 1 selects BCD counting, carried with `mode_wr` |
| first_byte | input | 1 | First byte of a two-byte reload written |
| reload_done | input | 1 | Full reload value written |
| reload_val | input | 16 | Reload value carried with `reload_done` |
| out_pin | output | 1 | Channel output |
| count_q | output | 16 | Live count for the latch stage |

## Verification
The channel is driven through each mode with slow, spaced ticks and with a continuous tick stream. The spaced ticks separate load ticks from decrement ticks, and the continuous stream runs a zero reload through its full binary and BCD spans. Gate patterns cover a low gate in flag mode, which must freeze the count, and a low gate in the triggered modes, which must not. Re-raised gates tell a retrigger apart from an ignored edge. A first-byte pulse followed by a new reload checks the halt, and runs past terminal count in both number systems check the wrap value and show that the output does not move again.

// File: rtl/timer_chan_pkg.sv
package timer_chan_pkg;

   typedef enum logic [1:0] {
      MODE_TC_FLAG  = 2'b00,
      MODE_ONESHOT  = 2'b01,
      MODE_STROBE   = 2'b10,
      MODE_STROBE_B = 2'b11
   } tmode_e;

   function automatic logic mode_is_flag(input tmode_e m);
      return m == MODE_TC_FLAG;
   endfunction

   function automatic logic mode_is_strobe(input tmode_e m);
      return m[1];
   endfunction

endpackage

// File: rtl/timer_gate_edge.sv
module timer_gate_edge #(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_in,
   output logic level,
   output logic rise
);
   if (STAGES < 1) begin : g_bad_stages
      $error("timer_gate_edge: STAGES must be at least 1");
   end

   logic [STAGES-1:0] sh_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= (sh_q << 1) | STAGES'(gate_in);
         prev_q <= sh_q[STAGES-1];
      end
   end

   assign level = sh_q[STAGES-1];
   assign rise  = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/timer_count_unit.sv
module timer_count_unit #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         store,
   input  logic [W-1:0] store_val,
   input  logic         load,
   input  logic         dec,
   input  logic         bcd,
   output logic [W-1:0] cnt,
   output logic         at_one
);
   localparam int DIGITS = W / 4;

   if (W % 4 != 0 || W < 4) begin : g_bad_width
      $error("timer_count_unit: W must be a positive multiple of 4");
   end

   logic [W-1:0] cnt_q;
   logic [W-1:0] rel_q;
   logic [W-1:0] bin_nx;
   logic [W-1:0] bcd_nx;

   assign bin_nx = cnt_q - W'(1);

   for (genvar i = 0; i < DIGITS; i++) begin : g_digit
      logic [3:0] d;
      logic       brw;
      assign d = cnt_q[4*i +: 4];
      if (i == 0) begin : g_lsd
         assign brw = 1'b1;
      end else begin : g_upper
         assign brw = (cnt_q[4*i-1:0] == '0);
      end
      assign bcd_nx[4*i +: 4] = brw ? ((d == 4'd0) ? 4'd9 : d - 4'd1) : d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rel_q <= '0;
      end else begin
         if (store) rel_q <= store_val;
         if (load)
            cnt_q <= rel_q;
         else if (dec)
            cnt_q <= bcd ? bcd_nx : bin_nx;
      end
   end

   assign cnt    = cnt_q;
   assign at_one = (cnt_q == W'(1));
endmodule

// File: rtl/timer_chan_ctrl.sv
module timer_chan_ctrl
   import timer_chan_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       gate_lvl,
   input  logic       gate_rise,
   input  logic       mode_wr,
   input  logic [1:0] mode_code,
   input  logic       bcd_sel,
   input  logic       first_byte,
   input  logic       reload_done,
   input  logic       cnt_at_one,
   output logic       load_cnt,
   output logic       dec_cnt,
   output logic       out_o,
   output logic       bcd_o,
   output logic [1:0] mode_o
);
   tmode_e mode_q;
   logic   bcd_q, armed_q, pend_q, run_q, out_q;
   logic   busy, tick_ok, is_flag, is_strobe, trig, tc;

   assign is_flag   = mode_is_flag(mode_q);
   assign is_strobe = mode_is_strobe(mode_q);
   assign busy      = mode_wr | first_byte | reload_done;
   assign tick_ok   = tick & ~busy;
   assign load_cnt  = tick_ok & pend_q;
   assign dec_cnt   = tick_ok & ~pend_q & run_q & (gate_lvl | ~is_flag);
   assign tc        = dec_cnt & cnt_at_one;
   assign trig      = gate_rise & armed_q & ~is_flag & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= MODE_TC_FLAG;
         bcd_q   <= 1'b0;
         armed_q <= 1'b0;
         pend_q  <= 1'b0;
         run_q   <= 1'b0;
         out_q   <= 1'b1;
      end else if (mode_wr) begin
         mode_q  <= tmode_e'(mode_code);
         bcd_q   <= bcd_sel;
         armed_q <= 1'b0;
         pend_q  <= 1'b0;
         run_q   <= 1'b0;
         out_q   <= (tmode_e'(mode_code) != MODE_TC_FLAG);
      end else if (first_byte) begin
         pend_q <= 1'b0;
         run_q  <= 1'b0;
      end else if (reload_done) begin
         run_q   <= 1'b0;
         pend_q  <= is_flag;
         armed_q <= ~is_flag;
         out_q   <= ~is_flag;
      end else begin
         if (load_cnt) begin
            pend_q <= 1'b0;
            run_q  <= 1'b1;
         end
         if (tc)
            out_q <= ~is_strobe;
         else if (tick_ok && is_strobe && !out_q)
            out_q <= 1'b1;
         if (trig) begin
            pend_q <= 1'b1;
            if (mode_q == MODE_ONESHOT) out_q <= 1'b0;
         end
      end
   end

   assign out_o  = out_q;
   assign bcd_o  = bcd_q;
   assign mode_o = mode_q;
endmodule

// File: rtl/oneshot_timer_chan.sv
module oneshot_timer_chan #(
   parameter int CNT_W       = 16,
   parameter int GATE_STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             gate,
   input  logic             mode_wr,
   input  logic [1:0]       mode_code,
   input  logic             bcd_sel,
   input  logic             first_byte,
   input  logic             reload_done,
   input  logic [CNT_W-1:0] reload_val,
   output logic             out_pin,
   output logic [CNT_W-1:0] count_q
);
   logic       gate_lvl, gate_rise, load_cnt, dec_cnt, at_one, bcd_q;
   logic [1:0] mode_q;

   timer_gate_edge #(.STAGES(GATE_STAGES)) u_gate (
      .clk(clk), .rst_n(rst_n), .gate_in(gate),
      .level(gate_lvl), .rise(gate_rise)
   );

   timer_chan_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .gate_lvl(gate_lvl), .gate_rise(gate_rise),
      .mode_wr(mode_wr), .mode_code(mode_code), .bcd_sel(bcd_sel),
      .first_byte(first_byte), .reload_done(reload_done),
      .cnt_at_one(at_one), .load_cnt(load_cnt), .dec_cnt(dec_cnt),
      .out_o(out_pin), .bcd_o(bcd_q), .mode_o(mode_q)
   );

   timer_count_unit #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .store(reload_done & ~mode_wr),
      .store_val(reload_val), .load(load_cnt), .dec(dec_cnt),
      .bcd(bcd_q), .cnt(count_q), .at_one(at_one)
   );
endmodule

// File: rtl/timer_chan_checker.sv
module timer_chan_checker #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         tick,
   input logic         mode_wr,
   input logic [1:0]   mode_code,
   input logic         first_byte,
   input logic         reload_done,
   input logic         out_pin,
   input logic [W-1:0] count_q,
   input logic [1:0]   mode_q,
   input logic         bcd_q,
   input logic         dec_cnt
);
   a_r2_flag_write_low: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && mode_code == 2'b00) |=> !out_pin);

   a_r6_trig_write_high: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && mode_code != 2'b00) |=> out_pin);

   a_r3_flag_tc_high: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b00 && dec_cnt && count_q == W'(1)) |=> out_pin);

   a_r4_wrap_value: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_cnt && count_q == '0) |=>
         (count_q == ($past(bcd_q) ? {(W/4){4'h9}} : {W{1'b1}})));

   a_r5_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (first_byte && !mode_wr) |=> $stable(count_q));

   a_r8_strobe_restore: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[1] && !out_pin && tick && !mode_wr && !first_byte && !reload_done)
         |=> out_pin);
endmodule

bind oneshot_timer_chan timer_chan_checker #(.W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .mode_wr(mode_wr),
   .mode_code(mode_code), .first_byte(first_byte), .reload_done(reload_done),
   .out_pin(out_pin), .count_q(count_q), .mode_q(mode_q), .bcd_q(bcd_q),
   .dec_cnt(dec_cnt)
);

// File: tb/oneshot_timer_chan_test.sv
module oneshot_timer_chan_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0, gate = 1'b1, mode_wr = 1'b0, bcd_sel = 1'b0;
   logic [1:0]  mode_code = 2'b00;
   logic        first_byte = 1'b0, reload_done = 1'b0;
   logic [15:0] reload_val = '0;
   logic        out_pin;
   logic [15:0] count_q;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   oneshot_timer_chan uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .mode_wr(mode_wr),
      .mode_code(mode_code), .bcd_sel(bcd_sel), .first_byte(first_byte),
      .reload_done(reload_done), .reload_val(reload_val),
      .out_pin(out_pin), .count_q(count_q)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   function automatic int bcd_to_int(input int v);
      int r = 0;
      for (int k = 3; k >= 0; k--) r = r * 10 + ((v >> (4 * k)) & 15);
      return r;
   endfunction

   function automatic int int_to_bcd(input int n);
      int r = 0;
      for (int k = 0; k < 4; k++) begin
         r = r | ((n % 10) << (4 * k));
         n = n / 10;
      end
      return r;
   endfunction

   function automatic int step_down(input int v, input bit bcd);
      int n;
      if (bcd) begin
         n = bcd_to_int(v);
         n = (n == 0) ? 9999 : n - 1;
         return int_to_bcd(n);
      end
      return (v + 65535) % 65536;
   endfunction

   int m_mode = 0, m_cnt = 0, m_rel = 0;
   bit m_bcd = 0, m_armed = 0, m_pend = 0, m_run = 0, m_out = 1;
   bit g_now = 0, g_old = 0;

   always @(posedge clk) begin
      bit edge_seen, tk, fires;
      if (!rst_n) begin
         m_mode = 0; m_cnt = 0; m_rel = 0; m_bcd = 0; m_armed = 0;
         m_pend = 0; m_run = 0; m_out = 1; g_now = 0; g_old = 0;
      end else begin
         edge_seen = g_now && !g_old;
         if (mode_wr) begin
            m_mode = mode_code; m_bcd = bcd_sel;
            m_armed = 0; m_pend = 0; m_run = 0; m_out = (mode_code != 0);
         end else if (first_byte) begin
            m_pend = 0; m_run = 0;
         end else if (reload_done) begin
            m_rel = reload_val; m_run = 0;
            if (m_mode == 0) begin m_pend = 1; m_out = 0; end
            else begin m_armed = 1; m_out = 1; end
         end else begin
            tk = tick;
            if (tk && m_pend) begin
               m_cnt = m_rel; m_pend = 0; m_run = 1;
               if (m_mode >= 2) m_out = 1;
            end else if (tk && m_run && (m_mode != 0 || g_now)) begin
               fires = (m_cnt == 1);
               m_cnt = step_down(m_cnt, m_bcd);
               if (fires) m_out = (m_mode < 2);
               else if (m_mode >= 2) m_out = 1;
            end else if (tk && m_mode >= 2) begin
               m_out = 1;
            end
            if (edge_seen && m_armed && m_mode != 0) begin
               m_pend = 1;
               if (m_mode == 1) m_out = 0;
            end
         end
         g_old = g_now;
         g_now = gate;
      end
   end

   always @(negedge clk) begin
      string tag;
      if (rst_n) begin
         tag = (m_mode == 0) ? "R2 model" : (m_mode == 1) ? "R6 model" : "R8 model";
         chk(out_pin === m_out, {tag, " out"}, out_pin, m_out);
         chk(count_q === 16'(m_cnt), {tag, " count"}, count_q, m_cnt);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr_mode(input logic [1:0] c, input logic b);
      @(negedge clk); mode_wr = 1; mode_code = c; bcd_sel = b;
      @(negedge clk); mode_wr = 0;
   endtask

   task automatic wr_reload(input logic [15:0] v);
      @(negedge clk); reload_done = 1; reload_val = v;
      @(negedge clk); reload_done = 0;
   endtask

   task automatic wr_first;
      @(negedge clk); first_byte = 1;
      @(negedge clk); first_byte = 0;
   endtask

   task automatic do_tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1;
         @(negedge clk); tick = 0;
      end
   endtask

   task automatic burst_ticks(input int n);
      @(negedge clk); tick = 1;
      repeat (n) @(negedge clk);
      tick = 0;
   endtask

   task automatic set_gate(input logic v);
      @(negedge clk); gate = v;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(out_pin === 1'b1, "R1 reset out", out_pin, 1);
      chk(count_q === 16'h0, "R1 reset count", count_q, 0);
      do_tick(3);
      chk(count_q === 16'h0, "R1 idle ticks", count_q, 0);

      // flag mode, binary
      wr_mode(2'b00, 0);
      chk(out_pin === 1'b0, "R2 mode write low", out_pin, 0);
      wr_reload(16'd5);
      do_tick(1);
      chk(count_q === 16'd5, "R2 load", count_q, 5);
      do_tick(2);
      chk(count_q === 16'd3, "R2 decrement", count_q, 3);
      set_gate(0);
      do_tick(2);
      chk(count_q === 16'd3, "R2 gate low holds", count_q, 3);
      set_gate(1);
      do_tick(2);
      chk(count_q === 16'd1 && out_pin === 1'b0, "R2 before tc", {out_pin, count_q}, 1);
      do_tick(1);
      chk(out_pin === 1'b1, "R3 tc high", out_pin, 1);
      do_tick(1);
      chk(count_q === 16'hFFFF, "R4 binary wrap", count_q, 16'hFFFF);
      chk(out_pin === 1'b1, "R4 out unchanged", out_pin, 1);
      do_tick(1);
      wr_reload(16'd4);
      chk(out_pin === 1'b0, "R3 reload drops out", out_pin, 0);
      do_tick(2);
      chk(count_q === 16'd3, "R2 reload used", count_q, 3);

      // halt on first byte
      wr_first;
      do_tick(2);
      chk(count_q === 16'd3, "R5 halted", count_q, 3);
      wr_reload(16'd9);
      chk(count_q === 16'd3, "R5 no early load", count_q, 3);
      do_tick(1);
      chk(count_q === 16'd9, "R5 load after halt", count_q, 9);

      // flag mode, BCD
      wr_mode(2'b00, 1);
      wr_reload(16'h0010);
      do_tick(2);
      chk(count_q === 16'h0009, "R4 bcd digit borrow", count_q, 16'h0009);
      do_tick(9);
      chk(count_q === 16'h0000 && out_pin === 1'b1, "R3 bcd tc", {out_pin, count_q}, 17'h10000);
      do_tick(1);
      chk(count_q === 16'h9999, "R4 bcd wrap", count_q, 16'h9999);

      // one-shot
      set_gate(0);
      wr_mode(2'b01, 0);
      chk(out_pin === 1'b1, "R6 mode write high", out_pin, 1);
      wr_reload(16'd3);
      do_tick(2);
      chk(count_q === 16'h9999 && out_pin === 1'b1, "R6 waits for gate", {out_pin, count_q}, 17'h19999);
      set_gate(1);
      chk(out_pin === 1'b0, "R6 trigger low", out_pin, 0);
      do_tick(1);
      chk(count_q === 16'd3, "R6 load after trigger", count_q, 3);
      do_tick(3);
      chk(out_pin === 1'b1 && count_q === 16'd0, "R3 one-shot tc", {out_pin, count_q}, 17'h10000);
      set_gate(0);
      do_tick(2);
      chk(count_q === 16'hFFFE && out_pin === 1'b1, "R7 gate low no effect", {out_pin, count_q}, 17'h1FFFE);
      set_gate(1);
      chk(out_pin === 1'b0, "R7 retrigger low", out_pin, 0);
      do_tick(1);
      chk(count_q === 16'd3, "R7 retrigger reload", count_q, 3);

      // strobe
      wr_mode(2'b10, 0);
      chk(out_pin === 1'b1, "R8 mode write high", out_pin, 1);
      wr_reload(16'd2);
      set_gate(0);
      set_gate(1);
      chk(out_pin === 1'b1, "R8 trigger keeps high", out_pin, 1);
      do_tick(1);
      chk(count_q === 16'd2, "R8 load", count_q, 2);
      do_tick(1);
      chk(out_pin === 1'b1 && count_q === 16'd1, "R8 before tc", {out_pin, count_q}, 17'h10001);
      do_tick(1);
      chk(out_pin === 1'b0, "R8 strobe low", out_pin, 0);
      do_tick(1);
      chk(out_pin === 1'b1 && count_q === 16'hFFFF, "R8 strobe ends", {out_pin, count_q}, 17'h1FFFF);
      set_gate(0);
      set_gate(1);
      do_tick(1);
      chk(count_q === 16'd2, "R7 strobe retrigger", count_q, 2);

      // zero reload, full span
      wr_mode(2'b00, 0);
      wr_reload(16'd0);
      do_tick(1);
      chk(count_q === 16'd0, "R9 zero loaded", count_q, 0);
      burst_ticks(65535);
      chk(count_q === 16'd1 && out_pin === 1'b0, "R9 binary span", {out_pin, count_q}, 1);
      do_tick(1);
      chk(out_pin === 1'b1, "R9 binary tc", out_pin, 1);
      wr_mode(2'b00, 1);
      wr_reload(16'd0);
      do_tick(1);
      burst_ticks(9999);
      chk(count_q === 16'h0001 && out_pin === 1'b0, "R9 bcd span", {out_pin, count_q}, 1);
      do_tick(1);
      chk(out_pin === 1'b1, "R9 bcd tc", out_pin, 1);

      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule